// File: doc/BRIEF.md
# Spike-Timing Synaptic Weight Updater

This block keeps one synaptic weight and adjusts it from the relative timing of spikes on its two sides. A step counter advances once per step tick. Each incoming presynaptic or postsynaptic spike is stamped with the counter value of its cycle. When the second spike of a pair arrives, the block forms the step difference, post time minus pre time, and looks up a change that decays exponentially with the size of that difference. A positive difference strengthens the weight and a negative one weakens it. The two directions have separate amplitudes and time constants. The changed weight is then clamped to the range zero to one.

The weight is an unsigned Q1.15 value, so 1.0 is 32768 and the reset value 0.5 is 16384. The decay tables hold one entry per step of |difference|. They are computed from the parameters during elaboration, with the default amplitudes 0.1 for potentiation and 0.05 for depression and a time constant of 20 steps for both. A one-cycle strobe marks every cycle in which a new weight has been written. The neuron model that produces the spikes lies outside this block, and so does any sharing of the updater between synapses.

Top module: `stdp_syn_weight`

## Requirements
- R1: A spike is stamped with the step count present in its cycle. The count advances on the clock edge that samples `step` high. A spike that finds no partner pending is only recorded: the strobe stays low and the weight is unchanged.
- R2: A post spike with a pre spike pending, at a difference d of 1 to TAB_LEN-1 steps, raises the weight by round(32768 * 0.1 * exp(-d/20)), within 3 LSB.
- R3: A pre spike with a post spike pending, at a difference of -d (d from 1 to TAB_LEN-1), lowers the weight by round(32768 * 0.05 * exp(-d/20)), within 3 LSB.
- R4: Pre and post spikes in the same cycle count as a difference of zero. There is no update, and both pending stamps are cleared.
- R5: After every update the weight is clamped to 0 to 32768 inclusive.
- R6: A completed pair with |difference| of TAB_LEN (128) steps or more causes no change and no strobe. The pair is consumed.
- R7: `upd` is high for exactly the cycle after the clock edge that sampled the completing spike, and `weight` shows the new value in that same cycle. Otherwise `upd` is low and `weight` holds.
- R8: Synchronous active-high reset sets the weight to 16384, drives `upd` low, clears both pending stamps and zeroes the step count.
- R9: A repeated spike on one side while the other side has nothing pending replaces that side's stamp. The latest spike is the one that pairs.
- R10: A completed pair whose two stamps are equal, with no step tick between the spikes, makes no update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Step tick that advances the step count |
| pre_spk | input | 1 | Presynaptic spike pulse |
| post_spk | input | 1 | Postsynaptic spike pulse |
| weight | output | WW | Current weight, unsigned Q1.15 |
| upd | output | 1 | High for one cycle when a new weight is written |

## Verification
The assertions assume that spikes are single-cycle pulses and that reset is held for at least one full cycle. They also assume that a pending stamp never waits 2^CW steps or more, since the step difference wraps at that point. The stimulus keeps every gap between spikes far below the counter range and reaches the out-of-window case with gaps just over 128 steps. The expected values are computed in real arithmetic from the exponential, which is why a small tolerance applies to the size of each step.

// File: rtl/stdp_syn_weight.sv
`timescale 1ns/1ps
module stdp_syn_weight #(
  parameter int WW      = 16,
  parameter int CW      = 16,
  parameter int TAB_LEN = 128,
  parameter int AMP_POT = 3277,
  parameter int AMP_DEP = 1638,
  parameter int TAU_POT = 20,
  parameter int TAU_DEP = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          pre_spk,
  input  logic          post_spk,
  output logic [WW-1:0] weight,
  output logic          upd
);
  localparam int IW  = $clog2(TAB_LEN);
  localparam int SW  = WW + 2;
  localparam int ONE = 1 << (WW - 1);
  localparam int HALF = ONE / 2;

  function automatic int unsigned decay(int unsigned amp, int unsigned tau, int unsigned d);
    longint unsigned one32 = 64'd1 << 32;
    longint unsigned t = longint'(tau);
    longint unsigned r32 = one32 - one32 / t + one32 / (2 * t * t)
                         - one32 / (6 * t * t * t) + one32 / (24 * t * t * t * t);
    longint unsigned r16 = r32 >> 16;
    longint unsigned acc = longint'(amp) << 16;
    for (int unsigned i = 0; i < d; i++) acc = (acc * r16) >> 16;
    return int'((acc + 64'd32768) >> 16);
  endfunction

  logic [WW-1:0] lut_pot [TAB_LEN];
  logic [WW-1:0] lut_dep [TAB_LEN];

  for (genvar g = 0; g < TAB_LEN; g++) begin : g_lut
    localparam int unsigned VP = decay(AMP_POT, TAU_POT, g);
    localparam int unsigned VD = decay(AMP_DEP, TAU_DEP, g);
    assign lut_pot[g] = VP[WW-1:0];
    assign lut_dep[g] = VD[WW-1:0];
  end

  logic [CW-1:0] now, pre_ts, post_ts, gap;
  logic          pre_pend, post_pend;
  logic          pot_evt, dep_evt, in_win, do_wr;
  logic [IW-1:0] idx;
  logic [WW-1:0] mag, nxt_w;
  logic signed [SW-1:0] sum;

  assign pot_evt = post_spk & ~pre_spk & pre_pend;
  assign dep_evt = pre_spk & ~post_spk & post_pend;
  assign gap     = pot_evt ? now - pre_ts : now - post_ts;
  assign in_win  = (gap != '0) && (gap < CW'(TAB_LEN));
  assign idx     = gap[IW-1:0];
  assign mag     = pot_evt ? lut_pot[idx] : lut_dep[idx];
  assign do_wr   = (pot_evt | dep_evt) & in_win;

  always_comb begin
    if (pot_evt) sum = $signed({2'b00, weight}) + $signed({2'b00, mag});
    else         sum = $signed({2'b00, weight}) - $signed({2'b00, mag});
    if (sum < 0)                       nxt_w = '0;
    else if (sum > $signed(SW'(ONE)))  nxt_w = WW'(ONE);
    else                               nxt_w = sum[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else if (step) now <= now + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_pend  <= 1'b0;
      post_pend <= 1'b0;
      pre_ts    <= '0;
      post_ts   <= '0;
    end else if ((pre_spk & post_spk) | pot_evt | dep_evt) begin
      pre_pend  <= 1'b0;
      post_pend <= 1'b0;
    end else if (pre_spk) begin
      pre_pend  <= 1'b1;
      pre_ts    <= now;
    end else if (post_spk) begin
      post_pend <= 1'b1;
      post_ts   <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      weight <= WW'(HALF);
      upd    <= 1'b0;
    end else begin
      upd <= do_wr;
      if (do_wr) weight <= nxt_w;
    end
  end
endmodule

module stdp_syn_weight_chk #(parameter int WW = 16) (
  input logic          clk,
  input logic          rst,
  input logic          pre_spk,
  input logic          post_spk,
  input logic          upd,
  input logic [WW-1:0] weight
);
  localparam logic [WW-1:0] ONE = WW'(1 << (WW - 1));

  p_weight_range_r5: assert property (@(posedge clk) disable iff (rst)
    weight <= ONE);

  p_coincident_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (pre_spk && post_spk) |=> !upd);

  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (rst)
    upd |-> $past(pre_spk ^ post_spk));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!upd && !$past(rst)) |-> $stable(weight));

  p_pot_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(post_spk && !pre_spk)) |-> weight >= $past(weight));

  p_dep_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(pre_spk && !post_spk)) |-> weight <= $past(weight));
endmodule

bind stdp_syn_weight stdp_syn_weight_chk #(.WW(WW)) i_chk (
  .clk(clk), .rst(rst), .pre_spk(pre_spk), .post_spk(post_spk),
  .upd(upd), .weight(weight)
);

// File: tb/test_stdp_syn_weight.sv
`timescale 1ns/1ps
module test_stdp_syn_weight;
  logic clk = 1'b0, rst = 1'b1, step = 1'b0, pre_spk = 1'b0, post_spk = 1'b0;
  logic [15:0] weight;
  logic upd;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  int ticks = 0, m_pre_ts = 0, m_post_ts = 0;
  bit m_pre = 1'b0, m_post = 1'b0, m_restamp = 1'b0;

  always #2.5 clk = ~clk;

  stdp_syn_weight i_stdp_syn_weight (
    .clk(clk), .rst(rst), .step(step), .pre_spk(pre_spk), .post_spk(post_spk),
    .weight(weight), .upd(upd)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int delta(bit pot, int d);
    real a = pot ? 0.1 : 0.05;
    return int'(32768.0 * a * $exp(-real'(d) / 20.0));
  endfunction

  task automatic apply(bit p, bit q, bit tk);
    int wb, d, raw, expw, diff;
    string tag;
    bit pot, pair;
    @(negedge clk);
    wb = int'(weight);
    pre_spk = p; post_spk = q; step = tk;
    pair = 1'b0; pot = 1'b0; d = 0; tag = "R1";
    if (p && q) begin
      tag = "R4"; m_pre = 0; m_post = 0;
    end else if (q && m_pre) begin
      pair = 1; pot = 1; d = ticks - m_pre_ts; tag = m_restamp ? "R9" : "R2";
      m_pre = 0; m_post = 0;
    end else if (p && m_post) begin
      pair = 1; pot = 0; d = ticks - m_post_ts; tag = m_restamp ? "R9" : "R3";
      m_pre = 0; m_post = 0;
    end else if (p) begin
      m_restamp = m_pre; m_pre = 1; m_pre_ts = ticks;
    end else if (q) begin
      m_restamp = m_post; m_post = 1; m_post_ts = ticks;
    end else tag = "R7";
    if (pair) m_restamp = 0;
    if (tk) ticks++;
    @(negedge clk);
    pre_spk = 0; post_spk = 0; step = 0;
    if (pair && d >= 1 && d < 128) begin
      raw = pot ? wb + delta(1, d) : wb - delta(0, d);
      expw = raw < 0 ? 0 : (raw > 32768 ? 32768 : raw);
      if (raw < 0 || raw > 32768) tag = "R5";
      diff = int'(weight) - expw;
      chk(upd == 1'b1, "R7 strobe", int'(upd), 1);
      chk(diff >= -3 && diff <= 3, tag, int'(weight), expw);
    end else begin
      if (pair) tag = (d == 0) ? "R10" : "R6";
      chk(upd == 1'b0, {tag, " strobe"}, int'(upd), 0);
      chk(int'(weight) == wb, tag, int'(weight), wb);
    end
  endtask

  task automatic ticks_n(int n);
    for (int i = 0; i < n; i++) apply(0, 0, 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    ticks = 0; m_pre = 0; m_post = 0; m_restamp = 0;
    chk(weight == 16'd16384, "R8 weight", int'(weight), 16384);
    chk(upd == 1'b0, "R8 strobe", int'(upd), 0);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R2 / R3 basic pairs
    apply(1, 0, 0); ticks_n(5); apply(0, 1, 0);
    apply(1, 0, 0); ticks_n(2); apply(0, 1, 0);
    apply(0, 1, 0); ticks_n(5); apply(1, 0, 0);
    // R1 spike on a tick cycle stamps the pre-increment count
    apply(1, 0, 1); ticks_n(1); apply(0, 1, 0);
    // R10 equal stamps
    apply(1, 0, 0); apply(0, 1, 0);
    // R4 coincident, pending cleared
    apply(1, 0, 0); ticks_n(3); apply(1, 1, 0); ticks_n(2); apply(0, 1, 0); apply(1, 0, 0);
    ticks_n(1); apply(0, 1, 0);
    // R9 restamp
    apply(1, 0, 0); ticks_n(10); apply(1, 0, 0); ticks_n(3); apply(0, 1, 0);
    // R6 out of window
    apply(1, 0, 0); ticks_n(128); apply(0, 1, 0);
    apply(0, 1, 0); ticks_n(127); apply(1, 0, 0);
    // R5 clamp high then low
    for (int i = 0; i < 12; i++) begin apply(1, 0, 0); ticks_n(1); apply(0, 1, 0); end
    chk(weight == 16'd32768, "R5 top", int'(weight), 32768);
    for (int i = 0; i < 25; i++) begin apply(0, 1, 0); ticks_n(1); apply(1, 0, 0); end
    chk(weight == 16'd0, "R5 bottom", int'(weight), 0);
    // R8 reset clears a pending stamp
    apply(1, 0, 0); ticks_n(2);
    do_reset();
    ticks_n(1); apply(0, 1, 0);
    apply(1, 0, 0); ticks_n(1); apply(0, 1, 0);
    // random mix
    for (int it = 0; it < 500; it++) begin
      int gap, r;
      gap = ($urandom_range(0, 19) == 0) ? $urandom_range(120, 135) : $urandom_range(0, 8);
      ticks_n(gap);
      r = $urandom_range(0, 9);
      if (r == 0) apply(1, 1, 0);
      else if (r <= 4) apply(1, 0, r == 4);
      else apply(0, 1, r == 8);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule